// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block raises an interrupt request towards the CPU once a programmed number of visible scanlines has been drawn. Software programs it through a small register window. One register loads the live 8-bit count directly. A second register holds the reload value. Two further registers switch counting off or on. Switching off also withdraws any pending request.

The rendering side sends a single-cycle strobe once per scanline. With it come the current line number and a flag that says whether rendering is active. On each strobe that qualifies, the count steps down by one first and is then tested. When the new value is zero, the count is refilled from the reload register and the interrupt line rises. The line stays high until software acknowledges it or the block is reset.

Address decoding keeps only bits 15, 14, 13 and 0 of the write address. Each register therefore appears at many aliased addresses.

Top module: `scan_irq_counter`

## Requirements
- R1: After reset, `irq_out` is 0 and the enable flag, the live count and the reload value are all 0.
- R2: A write whose address ANDed with 0xE001 equals 0xC000 puts `wr_data` into the live count on the next clock edge.
- R3: A write whose masked address equals 0xC001 puts `wr_data` into the reload value, and that value is used at the next refill.
- R4: Only address bits 15, 14, 13 and 0 are decoded, so 0xDFFE aliases the count register and 0xFFFE aliases the disable register. A write whose masked address matches none of the four registers (for example 0x7FFE) has no effect.
- R5: A write whose masked address equals 0xE000 clears the enable flag and drives `irq_out` low on the next edge.
- R6: A write whose masked address equals 0xE001 sets the enable flag.
- R7: A strobe counts only when `line_num` is in the range 0 to 239, `render_on` is 1 and the enable flag is set. In every other case the live count holds its value.
- R8: On a counting strobe the count is decremented. If the result is zero, the count is refilled from the reload value and `irq_out` goes to 1 on that same edge.
- R9: A counting strobe applied to a count of 0 wraps it to 255 and does not raise the interrupt.
- R10: Once high, `irq_out` stays high through further strobes and refills. Only a disable write or reset lowers it.
- R11: A count-register write that falls in the same cycle as a counting strobe wins. The written value is stored with no decrement and no interrupt.
- R12: A disable write in the same cycle as a strobe that reaches zero leaves `irq_out` low. The count is still refilled.
- R13: An enable write in the same cycle as a strobe does not let that strobe count. The strobe is judged against the flag as it stood before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| line_tick | input | 1 | One-cycle pulse per scanline |
| line_num | input | 9 | Current scanline number |
| render_on | input | 1 | Rendering active flag |
| irq_out | output | 1 | Interrupt request level |

## Verification
A register write and a scanline strobe can arrive in the same clock cycle. The bench drives three such collisions: a count write with a strobe, a disable write with the strobe that reaches zero, and an enable write with a strobe. Each case is judged by the later timing of `irq_out`, which shows whether the strobe decremented, refilled, or was ignored. A behavioural reference model, stepped on every edge, also has to agree with `irq_out` throughout these overlaps.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

  localparam int DEC_ADDR_W = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_COUNT,
    SEL_RELOAD,
    SEL_OFF,
    SEL_ON
  } reg_sel_e;

  // Classify a masked address into one of the register selects.
  function automatic reg_sel_e classify(input logic [DEC_ADDR_W-1:0] masked);
    case (masked)
      16'hC000: classify = SEL_COUNT;
      16'hC001: classify = SEL_RELOAD;
      16'hE000: classify = SEL_OFF;
      16'hE001: classify = SEL_ON;
      default:  classify = SEL_NONE;
    endcase
  endfunction

  // Down-step with natural wrap at the counter width.
  function automatic logic [7:0] step_down(input logic [7:0] v);
    step_down = v - 8'd1;
  endfunction

endpackage

// File: rtl/scan_irq_decode.sv
module scan_irq_decode
  import scan_irq_pkg::*;
#(
  parameter int ADDR_W = DEC_ADDR_W,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 16'hE001
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              ld_count,
  output logic              ld_reload,
  output logic              irq_off,
  output logic              irq_on
);

  logic [ADDR_W-1:0] masked;
  reg_sel_e          sel;

  assign masked = wr_addr & ADDR_MASK;

  always_comb begin
    sel = wr_en ? classify(masked) : SEL_NONE;
  end

  assign ld_count  = (sel == SEL_COUNT);
  assign ld_reload = (sel == SEL_RELOAD);
  assign irq_off   = (sel == SEL_OFF);
  assign irq_on    = (sel == SEL_ON);

endmodule

// File: rtl/scan_irq_count.sv
module scan_irq_count
  import scan_irq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic [LINE_W-1:0] line_num,
  input  logic              render_on,
  input  logic              en_q,
  input  logic              ld_count,
  input  logic              ld_reload,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              step,
  output logic              hit
);

  localparam logic [LINE_W-1:0] LAST = LINE_W'(LAST_LINE);

  logic [CNT_W-1:0] dec_val;
  logic             visible;

  assign visible = (line_num <= LAST);
  assign step    = line_tick && render_on && en_q && visible;
  assign dec_val = step_down(cnt_q);
  assign hit     = step && !ld_count && (dec_val == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld_count) begin
      cnt_q <= wr_data;
    end else if (step) begin
      cnt_q <= hit ? reload_q : dec_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (ld_reload) begin
      reload_q <= wr_data;
    end
  end

endmodule

// File: rtl/scan_irq_flag.sv
module scan_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_off,
  input  logic irq_on,
  input  logic hit,
  output logic en_q,
  output logic irq_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (irq_off) begin
      en_q <= 1'b0;
    end else if (irq_on) begin
      en_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_off) begin
      irq_q <= 1'b0;
    end else if (hit) begin
      irq_q <= 1'b1;
    end
  end

endmodule

// File: rtl/scan_irq_counter.sv
module scan_irq_counter
  import scan_irq_pkg::*;
#(
  parameter int ADDR_W    = DEC_ADDR_W,
  parameter int CNT_W     = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              line_tick,
  input  logic [LINE_W-1:0] line_num,
  input  logic              render_on,
  output logic              irq_out
);

  logic             ld_count;
  logic             ld_reload;
  logic             irq_off;
  logic             irq_on;
  logic             en_q;
  logic             step;
  logic             hit;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;

  scan_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .ld_count  (ld_count),
    .ld_reload (ld_reload),
    .irq_off   (irq_off),
    .irq_on    (irq_on)
  );

  scan_irq_count #(
    .CNT_W     (CNT_W),
    .LINE_W    (LINE_W),
    .LAST_LINE (LAST_LINE)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_tick (line_tick),
    .line_num  (line_num),
    .render_on (render_on),
    .en_q      (en_q),
    .ld_count  (ld_count),
    .ld_reload (ld_reload),
    .wr_data   (wr_data),
    .cnt_q     (cnt_q),
    .reload_q  (reload_q),
    .step      (step),
    .hit       (hit)
  );

  scan_irq_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_off (irq_off),
    .irq_on  (irq_on),
    .hit     (hit),
    .en_q    (en_q),
    .irq_q   (irq_out)
  );

endmodule

// File: rtl/scan_irq_counter_chk.sv
module scan_irq_counter_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] wr_data,
  input logic             ld_count,
  input logic             ld_reload,
  input logic             irq_off,
  input logic             irq_on,
  input logic             en_q,
  input logic             step,
  input logic             hit,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q,
  input logic             irq_out
);

  p_count_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_count |=> cnt_q == $past(wr_data));

  p_reload_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_reload |=> reload_q == $past(wr_data));

  p_one_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_count, ld_reload, irq_off, irq_on}));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_off |=> !irq_out && !en_q);

  p_enable_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_on |=> en_q);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_count && !step) |=> $stable(cnt_q));

  p_refill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cnt_q == $past(reload_q));

  p_rise_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(hit));

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_count && cnt_q == '0) |=> cnt_q == '1);

  p_level_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !irq_off) |=> irq_out);

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_count |-> !hit);

  p_ack_beats_hit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && irq_off) |=> !irq_out);

endmodule

bind scan_irq_counter scan_irq_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_data   (wr_data),
  .ld_count  (ld_count),
  .ld_reload (ld_reload),
  .irq_off   (irq_off),
  .irq_on    (irq_on),
  .en_q      (en_q),
  .step      (step),
  .hit       (hit),
  .cnt_q     (cnt_q),
  .reload_q  (reload_q),
  .irq_out   (irq_out)
);

// File: tb/scan_irq_counter_test.sv
`timescale 1ns/1ps
module scan_irq_counter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        line_tick = 1'b0;
  logic [8:0]  line_num = '0;
  logic        render_on = 1'b1;
  wire         irq_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural reference state
  int m_cnt, m_lat, m_en, m_irq;

  always #5 clk = ~clk;

  scan_irq_counter uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .line_tick (line_tick),
    .line_num  (line_num),
    .render_on (render_on),
    .irq_out   (irq_out)
  );

  always @(posedge clk or negedge rst_n) begin : model
    int a, nc, nl, ne, ni, d;
    bit q;
    if (!rst_n) begin
      m_cnt = 0; m_lat = 0; m_en = 0; m_irq = 0;
    end else begin
      a  = wr_en ? (int'(wr_addr) & 'hE001) : -1;
      q  = line_tick && render_on && (m_en != 0) && (line_num <= 239);
      nc = m_cnt; nl = m_lat; ne = m_en; ni = m_irq;
      if (q && a != 'hC000) begin
        d = (m_cnt + 255) % 256;
        if (d == 0) begin nc = m_lat; ni = 1; end
        else nc = d;
      end
      case (a)
        'hC000: nc = wr_data;
        'hC001: nl = wr_data;
        'hE000: begin ne = 0; ni = 0; end
        'hE001: ne = 1;
        default: ;
      endcase
      m_cnt = nc; m_lat = nl; m_en = ne; m_irq = ni;
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: irq_out=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!finished) chk("R8 model", irq_out, m_irq[0]);
  end

  task automatic cyc(input bit tick, input int line, input bit rend,
                     input bit we, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    line_tick = tick; line_num = 9'(line); render_on = rend;
    wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    line_tick = 0; wr_en = 0; render_on = 1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cyc(0, 10, 1, 1, a, d);
  endtask

  task automatic ticks(input int n, input int line = 10, input bit rend = 1);
    for (int i = 0; i < n; i++) cyc(1, line, rend, 0, 16'h0, 8'h0);
  endtask

  task automatic chk_now(input string tag, input logic exp);
    #1;
    chk(tag, irq_out, exp);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog: irq_out=%0b expected=done", irq_out);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_now("R1 reset level", 1'b0);

    // R1/R9: count starts at 0, first strobe wraps to 255 silently
    wr(16'hE001, 0);
    ticks(1);
    chk_now("R9 wrap no irq", 1'b0);
    ticks(254);
    chk_now("R9 count at 1", 1'b0);
    ticks(1);
    chk_now("R8 reach zero", 1'b1);

    // R5 acknowledge, R2 load count, R7 hold while disabled
    wr(16'hE000, 0);
    chk_now("R5 ack", 1'b0);
    wr(16'hC001, 3);
    wr(16'hC000, 2);
    ticks(5);
    chk_now("R7 disabled hold", 1'b0);
    wr(16'hE001, 0);
    ticks(1);
    chk_now("R2 count 2 -> 1", 1'b0);
    ticks(1);
    chk_now("R6 enabled hit", 1'b1);

    // R10 level persists across further strobes
    ticks(1);
    chk_now("R10 stays high", 1'b1);
    wr(16'hE000, 0);
    chk_now("R10 cleared by ack", 1'b0);

    // R3 reload value used: count is 2 now
    wr(16'hE001, 0);
    ticks(2);
    chk_now("R3 first hit", 1'b1);
    wr(16'hE000, 0);
    wr(16'hE001, 0);
    ticks(2);
    chk_now("R3 reload two left", 1'b0);
    ticks(1);
    chk_now("R3 reload 3 hit", 1'b1);

    // R7 line window and render flag
    wr(16'hE000, 0);
    wr(16'hC000, 1);
    wr(16'hE001, 0);
    ticks(1, 240, 1);
    chk_now("R7 line 240 ignored", 1'b0);
    ticks(1, 100, 0);
    chk_now("R7 render off ignored", 1'b0);
    ticks(1, 239, 1);
    chk_now("R7 line 239 counts", 1'b1);
    wr(16'hE000, 0);
    wr(16'hC000, 1);
    wr(16'hE001, 0);
    ticks(1, 0, 1);
    chk_now("R7 line 0 counts", 1'b1);

    // R4 aliasing
    wr(16'h7FFE, 0);
    chk_now("R4 unmatched ignored", 1'b1);
    wr(16'hFFFE, 0);
    chk_now("R4 alias ack", 1'b0);
    wr(16'hDFFE, 1);
    wr(16'hE001, 0);
    ticks(1);
    chk_now("R4 alias count", 1'b1);
    wr(16'hE000, 0);

    // R11 count write with strobe
    wr(16'hE001, 0);
    wr(16'hC000, 5);
    cyc(1, 10, 1, 1, 16'hC000, 1);
    chk_now("R11 write wins", 1'b0);
    ticks(1);
    chk_now("R11 next strobe hits", 1'b1);

    // R12 ack with hitting strobe (reload is 3)
    wr(16'hE000, 0);
    wr(16'hC000, 1);
    wr(16'hE001, 0);
    cyc(1, 10, 1, 1, 16'hE000, 0);
    chk_now("R12 ack beats hit", 1'b0);
    wr(16'hE001, 0);
    ticks(2);
    chk_now("R12 refilled to 3", 1'b0);
    ticks(1);
    chk_now("R12 refill hit", 1'b1);

    // R13 enable with strobe
    wr(16'hE000, 0);
    wr(16'hC000, 1);
    cyc(1, 10, 1, 1, 16'hE001, 0);
    chk_now("R13 old flag used", 1'b0);
    ticks(1);
    chk_now("R13 next strobe hits", 1'b1);

    // R1 reset clears a pending request
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk_now("R1 reset clears", 1'b0);
    wr(16'hE001, 0);
    ticks(1);
    chk_now("R1 count zero after reset", 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule